// File: doc/BRIEF.md
# Infrared Mark/Space Duration Capture

This block is the raw-mode receive front end of an infrared remote-control receiver. It watches the already demodulated, active-low receive line and measures how long each mark (line low, light present) and each space (line high, no light) lasts. The unit of measure is the carrier period, supplied as a one-cycle tick. At every transition of the line, the length of the interval that just ended goes into one 16-bit half of a 32-bit result word. Software then rebuilds the protocol from that series of durations.

Each capture raises a receive flag, which a one-cycle acknowledge pulse clears. A repeat flag shows whether the new length equals the previous length of the same kind. An overrun flag marks a transition that arrived before the previous one was acknowledged; the measurement from that transition is dropped. The live line level is also reported as a pulse-detect bit.

Top module: `ir_edge_timer`

## Requirements
- R1: `pdet_o` is the inverse of `rxd_i` after a two-stage synchroniser: low RXD reads 1 and high RXD reads 0. A change on `rxd_i` that is stable before a rising clock edge appears on `pdet_o` at the third rising edge. All capture outputs update on that same edge. After reset `pdet_o` is 0.
- R2: A duration is the number of clock cycles with `carrier_tick_i` high since the previous transition of `pdet_o`. The counter restarts from zero on every transition, including a transition whose measurement is dropped.
- R3: The duration counter saturates at 16'hFFFF instead of wrapping.
- R4: When `pdet_o` goes 0 to 1, the duration is written to `data_o[15:0]` as a space length. `data_o[31:16]` keeps its value.
- R5: When `pdet_o` goes 1 to 0, the duration is written to `data_o[31:16]` as a mark length. `data_o[15:0]` keeps its value.
- R6: After every transition of `pdet_o`, `rx_flag_o` is 1.
- R7: On each accepted measurement, `repeat_o` becomes 1 if the new duration equals the last accepted duration of the same kind (mark against mark, space against space), and 0 otherwise. The first accepted measurement of each kind after reset gives 0. `repeat_o` changes only on accepted measurements.
- R8: A transition that arrives while `rx_flag_o` is 1 and `ack_i` is 0 sets `overrun_o`. Its measurement is dropped: `data_o` and `repeat_o` keep their values.
- R9: `ack_i` high for one cycle clears `rx_flag_o` and `overrun_o` at the next rising edge. If a transition is captured in the same cycle as the acknowledge, that transition is accepted. `rx_flag_o` then stays 1 and `overrun_o` is 0.
- R10: After reset, `data_o` is 0 and `rx_flag_o`, `repeat_o` and `overrun_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rxd_i | input | 1 | Demodulated receive line, active low, asynchronous |
| carrier_tick_i | input | 1 | One-cycle pulse per carrier period |
| ack_i | input | 1 | Acknowledge pulse; clears the receive and overrun flags |
| data_o | output | 32 | Mark length in [31:16], space length in [15:0] |
| pdet_o | output | 1 | Synchronised pulse-detect level (1 = mark) |
| rx_flag_o | output | 1 | A measurement waits for acknowledge |
| repeat_o | output | 1 | Last accepted length equals the previous one of its kind |
| overrun_o | output | 1 | A transition arrived before acknowledge and was dropped |

## Verification
An acknowledge and a captured transition can fall on the same clock edge, and the block must then give priority to the acknowledge. The bench provokes this case directly. It raises `ack_i` while `rx_flag_o` is still set, timed so that it is high in exactly the cycle where the third synchroniser edge captures a new transition. The case is judged correct when the new space length appears in `data_o`, `rx_flag_o` reads 1 and `overrun_o` reads 0. The same transition without the acknowledge is run separately; there the bench expects `overrun_o` set and the data unchanged.

// File: rtl/ir_edge_pkg.sv
package ir_edge_pkg;

    localparam int DEF_DUR_W = 16;
    localparam int DEF_SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2
    } edge_kind_e;

endpackage

// File: rtl/ir_sync.sv
module ir_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] sh_d;
    logic [STAGES-1:0] sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sh_q <= {STAGES{RST_VAL}};
        end else begin
            sh_q <= sh_d;
        end
    end

    assign q_o = sh_q[STAGES-1];

endmodule

// File: rtl/ir_level_track.sv
module ir_level_track
    import ir_edge_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       rxd_sync_i,
    output logic       pdet_o,
    output edge_kind_e edge_o
);

    logic lvl_d;
    logic lvl_q;

    always_comb begin
        lvl_d = ~rxd_sync_i;
        if (lvl_d && !lvl_q) begin
            edge_o = EDGE_RISE;
        end else if (!lvl_d && lvl_q) begin
            edge_o = EDGE_FALL;
        end else begin
            edge_o = EDGE_NONE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lvl_q <= 1'b0;
        end else begin
            lvl_q <= lvl_d;
        end
    end

    assign pdet_o = lvl_q;

endmodule

// File: rtl/ir_dur_counter.sv
module ir_dur_counter #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         tick_i,
    input  logic         restart_i,
    output logic [W-1:0] count_o
);

    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic [W-1:0] cnt_d;
    logic [W-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart_i) begin
            cnt_d = '0;
        end else if (tick_i && (cnt_q != CNT_MAX)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count_o = cnt_q;

endmodule

// File: rtl/ir_capture.sv
module ir_capture
    import ir_edge_pkg::*;
#(
    parameter int W = 16
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  edge_kind_e     edge_i,
    input  logic [W-1:0]   dur_i,
    input  logic           ack_i,
    output logic [2*W-1:0] data_o,
    output logic           rx_flag_o,
    output logic           repeat_o,
    output logic           overrun_o
);

    typedef struct packed {
        logic [W-1:0] mark;
        logic [W-1:0] space;
        logic         rx;
        logic         rep;
        logic         ovr;
        logic         mark_vld;
        logic         space_vld;
    } cap_t;

    cap_t cap_d;
    cap_t cap_q;

    always_comb begin
        cap_d = cap_q;
        if (ack_i) begin
            cap_d.rx  = 1'b0;
            cap_d.ovr = 1'b0;
        end
        if (edge_i != EDGE_NONE) begin
            if (cap_q.rx && !ack_i) begin
                cap_d.ovr = 1'b1;
            end else begin
                cap_d.rx = 1'b1;
                if (edge_i == EDGE_RISE) begin
                    cap_d.rep       = cap_q.space_vld && (cap_q.space == dur_i);
                    cap_d.space     = dur_i;
                    cap_d.space_vld = 1'b1;
                end else begin
                    cap_d.rep      = cap_q.mark_vld && (cap_q.mark == dur_i);
                    cap_d.mark     = dur_i;
                    cap_d.mark_vld = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign data_o    = {cap_q.mark, cap_q.space};
    assign rx_flag_o = cap_q.rx;
    assign repeat_o  = cap_q.rep;
    assign overrun_o = cap_q.ovr;

endmodule

// File: rtl/ir_edge_timer.sv
module ir_edge_timer
    import ir_edge_pkg::*;
#(
    parameter int DUR_W       = DEF_DUR_W,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               rxd_i,
    input  logic               carrier_tick_i,
    input  logic               ack_i,
    output logic [2*DUR_W-1:0] data_o,
    output logic               pdet_o,
    output logic               rx_flag_o,
    output logic               repeat_o,
    output logic               overrun_o
);

    logic             rxd_sync;
    edge_kind_e       edge_kind;
    logic [DUR_W-1:0] dur;

    ir_sync #(
        .STAGES (SYNC_STAGES),
        .RST_VAL(1'b1)
    ) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (rxd_i),
        .q_o   (rxd_sync)
    );

    ir_level_track u_level (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rxd_sync_i(rxd_sync),
        .pdet_o    (pdet_o),
        .edge_o    (edge_kind)
    );

    ir_dur_counter #(
        .W(DUR_W)
    ) u_count (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (carrier_tick_i),
        .restart_i(edge_kind != EDGE_NONE),
        .count_o  (dur)
    );

    ir_capture #(
        .W(DUR_W)
    ) u_capture (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .edge_i   (edge_kind),
        .dur_i    (dur),
        .ack_i    (ack_i),
        .data_o   (data_o),
        .rx_flag_o(rx_flag_o),
        .repeat_o (repeat_o),
        .overrun_o(overrun_o)
    );

endmodule

// File: rtl/ir_edge_timer_chk.sv
module ir_edge_timer_chk #(
    parameter int DUR_W = 16
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               ack_i,
    input logic [2*DUR_W-1:0] data_o,
    input logic               pdet_o,
    input logic               rx_flag_o,
    input logic               repeat_o,
    input logic               overrun_o
);

    // R6
    edge_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(pdet_o) |-> rx_flag_o);

    // R4
    space_half_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(data_o[DUR_W-1:0]) |-> $rose(pdet_o));

    // R5
    mark_half_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(data_o[2*DUR_W-1:DUR_W]) |-> $fell(pdet_o));

    // R7
    repeat_only_on_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(repeat_o) |-> !$stable(pdet_o));

    // R8
    overrun_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(overrun_o) |-> ($past(rx_flag_o) && !$stable(pdet_o) && $stable(data_o)));

    // R9
    ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_i |=> ((!rx_flag_o || !$stable(pdet_o)) && !overrun_o));

endmodule

bind ir_edge_timer ir_edge_timer_chk #(
    .DUR_W(DUR_W)
) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ack_i    (ack_i),
    .data_o   (data_o),
    .pdet_o   (pdet_o),
    .rx_flag_o(rx_flag_o),
    .repeat_o (repeat_o),
    .overrun_o(overrun_o)
);

// File: tb/ir_edge_timer_bench.sv
module ir_edge_timer_bench;

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic        rxd = 1'b1;
    logic        tick = 1'b0;
    logic        ack = 1'b0;
    logic [31:0] data;
    logic        pdet, rxf, rep, ovr;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    ir_edge_timer u_ir_edge_timer (
        .clk_i         (clk),
        .rst_ni        (rst_ni),
        .rxd_i         (rxd),
        .carrier_tick_i(tick),
        .ack_i         (ack),
        .data_o        (data),
        .pdet_o        (pdet),
        .rx_flag_o     (rxf),
        .repeat_o      (rep),
        .overrun_o     (ovr)
    );

    // {new rxd, tick count, expected repeat, expected data}
    localparam int NV = 8;
    localparam logic [41:0] VEC [NV] = '{
        {1'b0, 8'd5, 1'b0, 32'h0000_0005},
        {1'b1, 8'd9, 1'b0, 32'h0009_0005},
        {1'b0, 8'd5, 1'b1, 32'h0009_0005},
        {1'b1, 8'd9, 1'b1, 32'h0009_0005},
        {1'b0, 8'd7, 1'b0, 32'h0009_0007},
        {1'b1, 8'd0, 1'b0, 32'h0000_0007},
        {1'b0, 8'd3, 1'b0, 32'h0000_0003},
        {1'b1, 8'd0, 1'b1, 32'h0000_0003}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic edge_to(input logic v);
        @(negedge clk) rxd = v;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_ack();
        @(negedge clk) ack = 1'b1;
        @(negedge clk) ack = 1'b0;
    endtask

    task automatic do_reset();
        rst_ni = 1'b0;
        rxd = 1'b1;
        tick = 1'b0;
        ack = 1'b0;
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        do_reset();
        chk("R10 data", data, 32'h0);
        chk("R10 flags", {29'd0, rxf, rep, ovr}, 32'h0);
        chk("R1 pdet reset", {31'd0, pdet}, 32'h0);

        // table walk: R2 R4 R5 R6 R7 R1
        for (int k = 0; k < NV; k++) begin
            ticks(int'(VEC[k][40:33]));
            edge_to(VEC[k][41]);
            chk($sformatf("R4/R5 data vec%0d", k), data, VEC[k][31:0]);
            chk($sformatf("R7 repeat vec%0d", k), {31'd0, rep}, {31'd0, VEC[k][32]});
            chk($sformatf("R6 rxflag vec%0d", k), {31'd0, rxf}, 32'd1);
            chk($sformatf("R1 pdet vec%0d", k), {31'd0, pdet}, {31'd0, ~VEC[k][41]});
            do_ack();
            chk($sformatf("R9 ack vec%0d", k), {30'd0, rxf, ovr}, 32'd0);
        end

        // R1 latency: pdet must not move before the third edge
        ticks(2);
        @(negedge clk) rxd = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 pdet early", {31'd0, pdet}, 32'd0);
        @(negedge clk);
        chk("R1 pdet third edge", {31'd0, pdet}, 32'd1);
        chk("R4 space latency", data, 32'h0000_0002);

        // overrun sequence from fresh reset
        do_reset();
        ticks(4);
        edge_to(1'b0);
        chk("R4 first space", data, 32'h0000_0004);
        ticks(6);
        edge_to(1'b1);
        chk("R8 overrun set", {31'd0, ovr}, 32'd1);
        chk("R8 data kept", data, 32'h0000_0004);
        chk("R8 repeat kept", {31'd0, rep}, 32'd0);
        chk("R1 pdet live on drop", {31'd0, pdet}, 32'd0);
        do_ack();
        chk("R9 clears overrun", {30'd0, rxf, ovr}, 32'd0);
        ticks(4);
        edge_to(1'b0);
        chk("R2 restart after drop", data, 32'h0000_0004);
        chk("R7 space repeat", {31'd0, rep}, 32'd1);
        do_ack();
        ticks(6);
        edge_to(1'b1);
        chk("R7 dropped mark not kept", {31'd0, rep}, 32'd0);
        chk("R5 mark", data, 32'h0006_0004);

        // ack in the capture cycle while flag is set
        ticks(3);
        @(negedge clk) rxd = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk) ack = 1'b1;
        @(negedge clk) ack = 1'b0;
        chk("R9 same-cycle data", data, 32'h0006_0003);
        chk("R9 same-cycle flag", {31'd0, rxf}, 32'd1);
        chk("R9 same-cycle no overrun", {31'd0, ovr}, 32'd0);

        // saturation
        do_ack();
        @(negedge clk) tick = 1'b1;
        repeat (70000) @(negedge clk);
        tick = 1'b0;
        edge_to(1'b1);
        chk("R3 saturate", data, 32'hFFFF_0003);
        do_ack();
        ticks(1);
        edge_to(1'b0);
        chk("R2 restart after saturate", data, 32'hFFFF_0001);

        summary();
        $finish;
    end

endmodule